// File: doc/BRIEF.md
# Status Register Unit with Free-Running Event Counters

This block serves the status-register accesses of a small 32-bit integer core. Each access carries a 12-bit register address, a two-bit operation code and a source operand. The operand is either a register value or a 5-bit immediate. In the same step the block returns the register's prior value and applies the update. The update either replaces the register, sets the operand's 1 bits, or clears the operand's 1 bits. The read value and the illegal flag are combinational from the request. The update lands at the next rising clock edge.

The block holds one writable scratch register and three 64-bit counters:

- a clock counter that advances on every cycle;
- a tick counter that advances on each cycle the real-time tick input is high;
- a retirement counter that advances on each cycle the retire input is high.

Software reads each counter as a low and a high 32-bit half. The counters accept no writes. A set or clear whose source index is 0 performs no write at all, so it serves as a pure read that never faults. Any write attempt to a counter, any unknown address and the reserved operation code raise the illegal flag and change nothing.

Software reads a consistent 64-bit value by reading high, then low, then high again, and retrying when the two high reads differ.

Top module: `sreg_unit`

## Requirements
- R1: While rst_n is low the scratch register holds 0 and each counter holds its reset parameter (default 0). A read during reset returns those values.
- R2: Operation codes are: 2'b01 write the operand, 2'b10 set the operand's 1 bits, 2'b11 clear the operand's 1 bits. rd_data shows the prior value in the request cycle. The new value is visible from the next cycle.
- R3: With req_imm high the operand is src_idx zero-extended to 32 bits, and src_data is ignored.
- R4: The clock counter advances by one every cycle out of reset. A carry from the low half into the high half takes effect in the same cycle. The low half is at 0xC00 and the high half at 0xC80.
- R5: The tick counter (low 0xC01, high 0xC81) advances once per cycle with tick high. The retirement counter (low 0xC02, high 0xC82) advances once per cycle with retire high.
- R6: A set or clear with src_idx equal to 0 writes nothing. This holds in both the register and the immediate form. On a counter address such an access reads without raising illegal.
- R7: A write (2'b01), or a set or clear with a nonzero src_idx, aimed at a counter address raises illegal. The counters continue counting as if no access had occurred.
- R8: An address other than 0x340, 0xC00-0xC02 or 0xC80-0xC82, or the reserved code 2'b00, raises illegal. Either case changes no state. rd_data is 0 whenever illegal is high.
- R9: The scratch register at 0x340 accepts all three operations. A write applies even when src_idx is 0. Without a legal write the scratch register keeps its value.
- R10: Reads of a counter's high half, low half and high half in consecutive cycles return a correct 64-bit value whenever the two high reads agree.
- R11: illegal stays low in every cycle where req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation code: 01 write, 10 set, 11 clear, 00 reserved |
| req_imm | input | 1 | Operand comes from src_idx as an immediate |
| src_idx | input | 5 | Source register index or 5-bit immediate |
| src_data | input | 32 | Source register value |
| tick | input | 1 | Real-time tick pulse |
| retire | input | 1 | Instruction-retired pulse |
| rd_data | output | 32 | Prior value of the addressed register |
| illegal | output | 1 | Access rejected |

## Verification
The hardest condition to reach is a carry out of a counter's low half. At that point a high-low-high read can straddle the rollover. From reset, reaching it takes four billion events. The bench therefore overrides the counters' reset parameters so that each low half starts a few hundred events below rollover. Repeated high-low-high triples then cross the carry within a few hundred cycles. Random tick and retire pulses carry the other two counters over their own rollover in the same window.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned NUM_CNT = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } sreg_op_e;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_SCRATCH = 3'd1,
        SEL_CLOCKS  = 3'd2,
        SEL_TICKS   = 3'd3,
        SEL_RETIRED = 3'd4
    } sreg_sel_e;

    localparam logic [ADDR_W-1:0] A_SCRATCH    = 12'h340;
    localparam logic [ADDR_W-1:0] A_CLOCKS_LO  = 12'hC00;
    localparam logic [ADDR_W-1:0] A_TICKS_LO   = 12'hC01;
    localparam logic [ADDR_W-1:0] A_RETIRED_LO = 12'hC02;
    localparam logic [ADDR_W-1:0] A_CLOCKS_HI  = 12'hC80;
    localparam logic [ADDR_W-1:0] A_TICKS_HI   = 12'hC81;
    localparam logic [ADDR_W-1:0] A_RETIRED_HI = 12'hC82;

endpackage

// File: rtl/sreg_counter.sv
module sreg_counter #(
    parameter int unsigned    W   = 64,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    // One adder across the full width: the low-to-high carry lands in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic [IDX_W-1:0]  idx,
    output sreg_sel_e         sel,
    output logic              hi_half,
    output logic              illegal,
    output logic              wr_en
);

    sreg_op_e op_e;
    logic     wants_write;
    logic     is_counter;

    assign op_e = sreg_op_e'(op);

    always_comb begin
        sel     = SEL_NONE;
        hi_half = 1'b0;
        case (addr)
            A_SCRATCH:    sel = SEL_SCRATCH;
            A_CLOCKS_LO:  sel = SEL_CLOCKS;
            A_TICKS_LO:   sel = SEL_TICKS;
            A_RETIRED_LO: sel = SEL_RETIRED;
            A_CLOCKS_HI:  begin sel = SEL_CLOCKS;  hi_half = 1'b1; end
            A_TICKS_HI:   begin sel = SEL_TICKS;   hi_half = 1'b1; end
            A_RETIRED_HI: begin sel = SEL_RETIRED; hi_half = 1'b1; end
            default:      sel = SEL_NONE;
        endcase
    end

    // A plain write always writes; set and clear write only with a nonzero source index.
    always_comb begin
        unique case (op_e)
            OP_WRITE:          wants_write = 1'b1;
            OP_SET, OP_CLEAR:  wants_write = |idx;
            default:           wants_write = 1'b0;
        endcase
    end

    assign is_counter = (sel == SEL_CLOCKS) || (sel == SEL_TICKS) || (sel == SEL_RETIRED);

    assign illegal = valid && ((sel == SEL_NONE) || (op_e == OP_NONE) ||
                               (is_counter && wants_write));

    assign wr_en = valid && !illegal && (sel == SEL_SCRATCH) && wants_write;

endmodule

// File: rtl/sreg_rmw.sv
module sreg_rmw
    import sreg_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);

    sreg_op_e op_e;
    assign op_e = sreg_op_e'(op);

    always_comb begin
        unique case (op_e)
            OP_WRITE: new_val = operand;
            OP_SET:   new_val = old_val | operand;
            OP_CLEAR: new_val = old_val & ~operand;
            default:  new_val = old_val;
        endcase
    end

endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
    import sreg_pkg::*;
#(
    parameter int unsigned         XLEN        = 32,
    parameter int unsigned         IDX_W       = 5,
    parameter logic [2*XLEN-1:0]   CLOCKS_RST  = '0,
    parameter logic [2*XLEN-1:0]   TICKS_RST   = '0,
    parameter logic [2*XLEN-1:0]   RETIRED_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_op,
    input  logic              req_imm,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [XLEN-1:0]   src_data,
    input  logic              tick,
    input  logic              retire,
    output logic [XLEN-1:0]   rd_data,
    output logic              illegal
);

    localparam int unsigned CNT_W = 2 * XLEN;

    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   clocks_now;
    logic [CNT_W-1:0]   ticks_now;
    logic [CNT_W-1:0]   retired_now;
    logic [XLEN-1:0]    scratch_q;
    logic [XLEN-1:0]    operand;
    logic [XLEN-1:0]    old_val;
    logic [XLEN-1:0]    new_val;
    logic [CNT_W-1:0]   cnt_pick;
    sreg_sel_e          sel;
    logic               hi_half;
    logic               wr_en;

    // Counter order: 0 clock cycles, 1 ticks, 2 retirements.
    assign cnt_inc = {retire, tick, 1'b1};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam logic [CNT_W-1:0] G_RST = (g == 0) ? CLOCKS_RST :
                                             (g == 1) ? TICKS_RST  : RETIRED_RST;
        sreg_counter #(
            .W   (CNT_W),
            .RST (G_RST)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .value (cnt_val[g])
        );
    end

    assign clocks_now  = cnt_val[0];
    assign ticks_now   = cnt_val[1];
    assign retired_now = cnt_val[2];

    sreg_decode #(
        .IDX_W (IDX_W)
    ) u_dec (
        .valid   (req_valid),
        .addr    (req_addr),
        .op      (req_op),
        .idx     (src_idx),
        .sel     (sel),
        .hi_half (hi_half),
        .illegal (illegal),
        .wr_en   (wr_en)
    );

    assign operand = req_imm ? {{(XLEN-IDX_W){1'b0}}, src_idx} : src_data;

    always_comb begin
        cnt_pick = '0;
        old_val  = '0;
        unique case (sel)
            SEL_SCRATCH: old_val  = scratch_q;
            SEL_CLOCKS:  cnt_pick = clocks_now;
            SEL_TICKS:   cnt_pick = ticks_now;
            SEL_RETIRED: cnt_pick = retired_now;
            default:     old_val  = '0;
        endcase
        if (sel != SEL_SCRATCH && sel != SEL_NONE) begin
            old_val = hi_half ? cnt_pick[CNT_W-1:XLEN] : cnt_pick[XLEN-1:0];
        end
    end

    assign rd_data = illegal ? '0 : old_val;

    sreg_rmw #(
        .XLEN (XLEN)
    ) u_rmw (
        .op      (req_op),
        .old_val (old_val),
        .operand (operand),
        .new_val (new_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
        end else if (wr_en) begin
            scratch_q <= new_val;
        end
    end

endmodule

// File: rtl/sreg_unit_chk.sv
module sreg_unit_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [11:0]       req_addr,
    input logic [1:0]        req_op,
    input logic [IDX_W-1:0]  src_idx,
    input logic              tick,
    input logic              retire,
    input logic [XLEN-1:0]   rd_data,
    input logic              illegal,
    input logic [2*XLEN-1:0] clocks_now,
    input logic [2*XLEN-1:0] ticks_now,
    input logic [2*XLEN-1:0] retired_now,
    input logic [XLEN-1:0]   scratch_q
);

    localparam int unsigned CNT_W = 2 * XLEN;

    logic armed_q;
    logic cnt_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign cnt_addr = (req_addr inside {12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82});

    assert_clock_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> clocks_now == $past(clocks_now) + CNT_W'(1));

    assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ticks_now == $past(ticks_now) + CNT_W'($past(tick)));

    assert_retire_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> retired_now == $past(retired_now) + CNT_W'($past(retire)));

    assert_index0_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cnt_addr && req_op[1] && src_idx == '0) |-> !illegal);

    assert_counter_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cnt_addr && req_op == 2'b01) |-> illegal);

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> rd_data == '0);

    assert_scratch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(req_valid && req_addr == 12'h340 && !illegal)) |-> $stable(scratch_q));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !illegal);

endmodule

bind sreg_unit sreg_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_op      (req_op),
    .src_idx     (src_idx),
    .tick        (tick),
    .retire      (retire),
    .rd_data     (rd_data),
    .illegal     (illegal),
    .clocks_now  (clocks_now),
    .ticks_now   (ticks_now),
    .retired_now (retired_now),
    .scratch_q   (scratch_q)
);

// File: tb/sreg_unit_test.sv
`timescale 1ns/1ps
module sreg_unit_test;

    localparam logic [63:0] CLK0 = 64'h0000_0001_FFFF_FF00;
    localparam logic [63:0] TCK0 = 64'h0000_0000_FFFF_FFF0;
    localparam logic [63:0] RET0 = 64'h0000_0002_FFFF_FFE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic        req_imm = 1'b0;
    logic [4:0]  src_idx = '0;
    logic [31:0] src_data = '0;
    logic        tick = 1'b0;
    logic        retire = 1'b0;
    logic [31:0] rd_data;
    logic        illegal;

    int  checks = 0;
    int  errors = 0;
    bit  pulses_on = 1'b0;

    logic [63:0] m_clk = CLK0;
    logic [63:0] m_tck = TCK0;
    logic [63:0] m_ret = RET0;
    logic [31:0] m_scr = '0;

    always #10 clk = ~clk;

    sreg_unit #(
        .CLOCKS_RST  (CLK0),
        .TICKS_RST   (TCK0),
        .RETIRED_RST (RET0)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_op    (req_op),
        .req_imm   (req_imm),
        .src_idx   (src_idx),
        .src_data  (src_data),
        .tick      (tick),
        .retire    (retire),
        .rd_data   (rd_data),
        .illegal   (illegal)
    );

    // Counter model built from R1, R4 and R5.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_clk <= CLK0;
            m_tck <= TCK0;
            m_ret <= RET0;
        end else begin
            m_clk <= m_clk + 64'd1;
            if (tick)   m_tck <= m_tck + 64'd1;
            if (retire) m_ret <= m_ret + 64'd1;
        end
    end

    function automatic bit f_impl(input logic [11:0] a);
        return a inside {12'h340, 12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82};
    endfunction

    function automatic bit f_is_cnt(input logic [11:0] a);
        return f_impl(a) && a != 12'h340;
    endfunction

    function automatic bit f_ill(input logic [11:0] a, input logic [1:0] op, input logic [4:0] idx);
        if (!f_impl(a) || op == 2'b00) return 1'b1;
        if (f_is_cnt(a) && (op == 2'b01 || idx != 5'd0)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] f_read(input logic [11:0] a);
        case (a)
            12'h340: return m_scr;
            12'hC00: return m_clk[31:0];
            12'hC80: return m_clk[63:32];
            12'hC01: return m_tck[31:0];
            12'hC81: return m_tck[63:32];
            12'hC02: return m_ret[31:0];
            12'hC82: return m_ret[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] f_next(input logic [1:0] op, input logic [31:0] old, input logic [31:0] opd);
        case (op)
            2'b01:   return opd;
            2'b10:   return old | opd;
            2'b11:   return old & ~opd;
            default: return old;
        endcase
    endfunction

    function automatic string f_tag(input logic [11:0] a, input logic [1:0] op, input logic [4:0] idx);
        if (f_ill(a, op, idx)) return (f_impl(a) && op != 2'b00) ? "R7" : "R8";
        if (a == 12'h340) return "R2";
        if (a == 12'hC00 || a == 12'hC80) return "R4";
        return "R5";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive_pulses();
        tick   = pulses_on ? 1'($urandom % 2) : 1'b0;
        retire = pulses_on ? 1'($urandom % 2) : 1'b0;
    endtask

    task automatic do_op(input logic [11:0] a, input logic [1:0] op, input bit imm,
                         input logic [4:0] idx, input logic [31:0] data,
                         input string tag, output logic [31:0] got);
        logic [31:0] opd;
        logic [31:0] exp_rd;
        bit          exp_ill;
        bit          do_wr;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_op    = op;
        req_imm   = imm;
        src_idx   = idx;
        src_data  = data;
        drive_pulses();
        #1;
        exp_ill = f_ill(a, op, idx);
        exp_rd  = exp_ill ? 32'h0 : f_read(a);
        check(illegal === exp_ill, tag, {31'b0, illegal}, {31'b0, exp_ill}, "illegal flag");
        check(rd_data === exp_rd, tag, rd_data, exp_rd, "read value");
        got   = rd_data;
        opd   = imm ? {27'b0, idx} : data;
        do_wr = !exp_ill && a == 12'h340 && (op == 2'b01 || idx != 5'd0) && rst_n;
        @(posedge clk);
        #1;
        if (do_wr) m_scr = f_next(op, m_scr, opd);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
            drive_pulses();
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        logic [31:0] h1;
        logic [31:0] lo;
        logic [31:0] h2;
        logic [63:0] v;
        void'($urandom(32'd20240611));

        // R1: reads while held in reset
        idle(3);
        do_op(12'h340, 2'b10, 1'b0, 5'd0, 32'h0, "R1", got);
        check(got === 32'h0, "R1", got, 32'h0, "scratch in reset");
        do_op(12'hC00, 2'b10, 1'b0, 5'd0, 32'h0, "R1", got);
        check(got === CLK0[31:0], "R1", got, CLK0[31:0], "clock low in reset");
        do_op(12'hC82, 2'b11, 1'b1, 5'd0, 32'h0, "R1", got);
        check(got === RET0[63:32], "R1", got, RET0[63:32], "retire high in reset");

        @(negedge clk);
        rst_n = 1'b1;
        pulses_on = 1'b1;

        // R2 / R9: scratch write, set, clear
        do_op(12'h340, 2'b01, 1'b0, 5'd7, 32'hDEADBEEF, "R2", got);
        do_op(12'h340, 2'b10, 1'b0, 5'd0, 32'hFFFFFFFF, "R6", got);
        check(got === 32'hDEADBEEF, "R2", got, 32'hDEADBEEF, "write then read");
        do_op(12'h340, 2'b10, 1'b1, 5'h10, 32'hFFFF0000, "R3", got);
        do_op(12'h340, 2'b11, 1'b0, 5'd3, 32'hFFFF0000, "R2", got);
        check(got === 32'hDEADBEFF, "R3", got, 32'hDEADBEFF, "immediate set ignores src_data");
        do_op(12'h340, 2'b11, 1'b1, 5'd0, 32'hFFFFFFFF, "R6", got);
        check(got === 32'h0000BEFF, "R2", got, 32'h0000BEFF, "clear applied");
        do_op(12'h340, 2'b01, 1'b1, 5'h1F, 32'hFFFFFFFF, "R3", got);
        do_op(12'h340, 2'b10, 1'b0, 5'd0, 32'h0, "R3", got);
        check(got === 32'h0000001F, "R3", got, 32'h0000001F, "zero-extended immediate");
        do_op(12'h340, 2'b01, 1'b0, 5'd0, 32'h0, "R9", got);
        do_op(12'h340, 2'b10, 1'b0, 5'd0, 32'h0, "R9", got);
        check(got === 32'h0, "R9", got, 32'h0, "write from index 0 applies");
        do_op(12'h340, 2'b01, 1'b0, 5'd9, 32'h13579BDF, "R9", got);

        // R4 / R5: counter halves
        do_op(12'hC00, 2'b10, 1'b0, 5'd0, 32'h0, "R4", got);
        do_op(12'hC80, 2'b11, 1'b1, 5'd0, 32'h0, "R4", got);
        do_op(12'hC01, 2'b10, 1'b0, 5'd0, 32'h0, "R5", got);
        do_op(12'hC81, 2'b10, 1'b0, 5'd0, 32'h0, "R5", got);
        do_op(12'hC02, 2'b11, 1'b0, 5'd0, 32'h0, "R5", got);

        // R7 / R8: rejected accesses leave state untouched
        do_op(12'hC00, 2'b01, 1'b0, 5'd0, 32'h0, "R7", got);
        do_op(12'hC00, 2'b10, 1'b0, 5'd0, 32'h0, "R7", got);
        do_op(12'hC81, 2'b10, 1'b1, 5'd4, 32'h0, "R7", got);
        do_op(12'hC02, 2'b11, 1'b0, 5'd2, 32'hFFFFFFFF, "R7", got);
        do_op(12'h341, 2'b01, 1'b0, 5'd1, 32'h0, "R8", got);
        do_op(12'h340, 2'b00, 1'b0, 5'd1, 32'h0, "R8", got);
        do_op(12'h340, 2'b10, 1'b0, 5'd0, 32'h0, "R8", got);
        check(got === 32'h13579BDF, "R8", got, 32'h13579BDF, "scratch kept after rejected access");

        // R11: idle cycle with a bad address present
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 12'hC00;
        req_op    = 2'b01;
        src_idx   = 5'd5;
        #1;
        check(illegal === 1'b0, "R11", {31'b0, illegal}, 32'h0, "illegal while idle");

        // R10 / R4: high-low-high triples across the low-half rollover
        for (int i = 0; i < 150; i++) begin
            do_op(12'hC80, 2'b10, 1'b0, 5'd0, 32'h0, "R10", h1);
            do_op(12'hC00, 2'b10, 1'b0, 5'd0, 32'h0, "R10", lo);
            do_op(12'hC80, 2'b10, 1'b0, 5'd0, 32'h0, "R10", h2);
            if (h1 == h2) begin
                v = m_clk - 64'd2;
                check({h1, lo} === v, "R10", lo, v[31:0], "consistent 64-bit read");
            end
        end
        do_op(12'hC80, 2'b10, 1'b0, 5'd0, 32'h0, "R4", got);
        check(got === 32'h2, "R4", got, 32'h2, "carry reached high half");
        do_op(12'hC81, 2'b10, 1'b0, 5'd0, 32'h0, "R5", got);
        check(got === 32'h1, "R5", got, 32'h1, "tick carry reached high half");

        // Random mix of all addresses and operations
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [1:0]  op;
            logic [4:0]  idx;
            case ($urandom % 11)
                0: a = 12'h340;  1: a = 12'hC00;  2: a = 12'hC01;  3: a = 12'hC02;
                4: a = 12'hC80;  5: a = 12'hC81;  6: a = 12'hC82;  7: a = 12'h341;
                8: a = 12'hC03;  9: a = 12'h000;  default: a = 12'hB00;
            endcase
            op  = 2'($urandom % 4);
            idx = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom % 32);
            do_op(a, op, 1'($urandom % 2), idx, $urandom, f_tag(a, op, idx), got);
        end

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule